// File: doc/BRIEF.md
# Double-Buffered Eight-Channel DAC Register Bank

This block is the host-facing register file of an eight-channel analog output card. A host reaches it through a simple bus made of a word address, separate read and write strobes, 16-bit write data, registered read data and an acknowledge. Each channel keeps two registers. The first is a staging (preload) register. The second is the output register, which drives that channel's converter code bus and its load pin.

Software updates the outputs in one of three ways. In the first, it stages values in any number of channels and then issues one broadcast transfer that moves every staged value to the outputs on the same clock edge. In the second, it writes a single channel's output directly. In the third, it clears every channel at once. The block also keeps one bit that selects the card's bus clock rate. The converters themselves, bus arbitration and identification storage are outside the block.

Top module: `dac_dbuf_regbank`

## Requirements
- R1: A write to offset 0x00, 0x02, …, 0x0E stores the write data in the staging register of channel (offset/2), counting from 0. It changes no converter code and raises no load pulse.
- R2: A write to offset 0x10 copies every staging register into its output register on the same edge. In the next cycle all `dac_code` lanes show the staged values and every `dac_load` bit is 1.
- R3: A write to offset 0x20, 0x22, …, 0x2E loads the write data straight into the output register of channel ((offset−0x20)/2). That channel's staging register keeps its earlier value, so a later 0x10 transfer still delivers the staged value.
- R4: A `dac_load` bit is 1 for exactly the one cycle that follows the edge that wrote its output register, which is also the first cycle in which the new code shows on `dac_code`. In every other cycle it is 0.
- R5: A write to offset 0x18 sets both registers of every channel to zero. `dac_clear` is then 1 for the following cycle and no `dac_load` bit rises.
- R6: A write to offset 0x1A stores write data bit 0 in `clk_sel_8m`: 1 selects the 8 MHz bus clock and 0 selects the 32 MHz one. The bit reads 0 after reset.
- R7: Address bit 0 takes no part in decoding, so an odd offset acts exactly like the even offset below it.
- R8: A read returns its result on `bus_rdata` in the acknowledge cycle. The staging window returns the staging value, the direct window returns the output value, and 0x1A returns the select bit in bit 0 with all other bits zero. Offsets 0x10, 0x18 and every undecoded offset return zero. Outside acknowledge cycles `bus_rdata` is zero.
- R9: `bus_ack` is 1 in the cycle after each cycle in which `bus_wr` or `bus_rd` is sampled high, and 0 otherwise. No wait states are added.
- R10: While `rst_n` is low, all registers, `dac_code`, `dac_load`, `dac_clear`, `bus_ack` and `bus_rdata` are zero.
- R11: A write to an undecoded offset (0x12–0x16, 0x1C–0x1E, 0x30–0x3E) changes no staging register, no output register and no select bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 6 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, sampled on the rising edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while `bus_ack` is high |
| bus_ack | output | 1 | Access acknowledge, one cycle after the strobe |
| dac_code | output | 128 | Output register contents, channel n in bits 16n+15:16n |
| dac_load | output | 8 | Per-channel converter load pulse |
| dac_clear | output | 1 | Converter clear pulse |
| clk_sel_8m | output | 1 | Bus clock rate select, 1 = 8 MHz |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle and that the bus holds one access per strobe cycle. Under those conditions each edge performs at most one register operation, so an output register can change only through its own load pulse or through a clear. The stimulus drives exactly one strobe per access task and returns the strobes to zero between accesses. Random traffic draws a single operation per cycle, so the inputs never leave this space.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

   // Register operation selected by the current bus address
   typedef enum logic [2:0] {
      OP_NONE,
      OP_STAGE,
      OP_DIRECT,
      OP_XFER,
      OP_CLEAR,
      OP_CLKSEL
   } dac_op_e;

   // Word (byte offset / 2) addresses of the single registers
   localparam logic [4:0] WADDR_XFER   = 5'h08;
   localparam logic [4:0] WADDR_CLEAR  = 5'h0C;
   localparam logic [4:0] WADDR_CLKSEL = 5'h0D;

   // Window selectors on byte offset bits [5:4]
   localparam logic [1:0] WIN_STAGE  = 2'b00;
   localparam logic [1:0] WIN_DIRECT = 2'b10;

   // Slots per channel window (fixed by the map)
   localparam int WIN_SLOTS = 8;

endpackage

// File: rtl/dac_dbuf_decode.sv
module dac_dbuf_decode
   import dac_dbuf_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int ADDR_W = 6
) (
   input  logic [ADDR_W-1:0] addr,
   output dac_op_e           op,
   output logic [2:0]        ch
);

   logic       hi_zero;
   logic [4:0] waddr;
   logic       ch_ok;
   logic       unused_lsb;

   generate
      if (ADDR_W > 6) begin : g_hi
         assign hi_zero = (addr[ADDR_W-1:6] == '0);
      end else begin : g_nohi
         assign hi_zero = 1'b1;
      end
   endgenerate

   assign waddr      = addr[5:1];
   assign ch         = addr[3:1];
   assign ch_ok      = (int'(ch) < NUM_CH);
   assign unused_lsb = addr[0];

   always_comb begin
      op = OP_NONE;
      if (hi_zero) begin
         if (addr[5:4] == WIN_STAGE && !addr[3]) begin
            op = OP_NONE;
         end
         if (addr[5:4] == WIN_STAGE && ch_ok && waddr < WADDR_XFER) begin
            op = OP_STAGE;
         end else if (addr[5:4] == WIN_DIRECT && ch_ok) begin
            op = OP_DIRECT;
         end else if (waddr == WADDR_XFER) begin
            op = OP_XFER;
         end else if (waddr == WADDR_CLEAR) begin
            op = OP_CLEAR;
         end else if (waddr == WADDR_CLKSEL) begin
            op = OP_CLKSEL;
         end
      end
   end

endmodule

// File: rtl/dac_dbuf_channel.sv
module dac_dbuf_channel #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stage_we,
   input  logic              direct_we,
   input  logic              xfer,
   input  logic              clr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] stage_q,
   output logic [DATA_W-1:0] out_q,
   output logic              load_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_q <= '0;
      end else if (clr) begin
         stage_q <= '0;
      end else if (stage_we) begin
         stage_q <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q  <= '0;
         load_q <= 1'b0;
      end else begin
         load_q <= !clr && (direct_we || xfer);
         if (clr) begin
            out_q <= '0;
         end else if (direct_we) begin
            out_q <= wdata;
         end else if (xfer) begin
            out_q <= stage_q;
         end
      end
   end

   // R1: staging never reaches the output by itself
   a_r1_stage_holds_output: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_we && !direct_we && !xfer && !clr) |=> $stable(out_q));

   // R4: output moves only with its load pulse or a clear
   a_r4_change_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_q && !$past(clr)) |-> $stable(out_q));

   // R5: a clear leaves both registers at zero
   a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (out_q == '0 && stage_q == '0 && !load_q));

endmodule

// File: rtl/dac_dbuf_regbank.sv
module dac_dbuf_regbank
   import dac_dbuf_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 6
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        bus_addr,
   input  logic                     bus_wr,
   input  logic                     bus_rd,
   input  logic [DATA_W-1:0]        bus_wdata,
   output logic [DATA_W-1:0]        bus_rdata,
   output logic                     bus_ack,
   output logic [NUM_CH*DATA_W-1:0] dac_code,
   output logic [NUM_CH-1:0]        dac_load,
   output logic                     dac_clear,
   output logic                     clk_sel_8m
);

   localparam int CODE_W = NUM_CH * DATA_W;

   generate
      if (NUM_CH < 1 || NUM_CH > WIN_SLOTS) begin : g_bad_ch
         $error("NUM_CH must lie in 1..8");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("ADDR_W must be at least 6");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("DATA_W must be positive");
      end
   endgenerate

   dac_op_e           op;
   logic [2:0]        sel_ch;
   logic              do_clear;
   logic              do_xfer;
   logic [DATA_W-1:0] stage_arr [NUM_CH];
   logic [DATA_W-1:0] out_arr   [NUM_CH];
   logic [DATA_W-1:0] rd_mux;

   dac_dbuf_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_decode (
      .addr (bus_addr),
      .op   (op),
      .ch   (sel_ch)
   );

   assign do_clear = bus_wr && (op == OP_CLEAR);
   assign do_xfer  = bus_wr && (op == OP_XFER);

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      logic hit;
      assign hit = (int'(sel_ch) == i);

      dac_dbuf_channel #(.DATA_W(DATA_W)) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .stage_we  (bus_wr && op == OP_STAGE && hit),
         .direct_we (bus_wr && op == OP_DIRECT && hit),
         .xfer      (do_xfer),
         .clr       (do_clear),
         .wdata     (bus_wdata),
         .stage_q   (stage_arr[i]),
         .out_q     (out_arr[i]),
         .load_q    (dac_load[i])
      );

      assign dac_code[i*DATA_W +: DATA_W] = out_arr[i];
   end

   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         if (int'(sel_ch) == k && op == OP_STAGE)  rd_mux = stage_arr[k];
         if (int'(sel_ch) == k && op == OP_DIRECT) rd_mux = out_arr[k];
      end
      if (op == OP_CLKSEL) rd_mux = {{(DATA_W-1){1'b0}}, clk_sel_8m};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ack    <= 1'b0;
         bus_rdata  <= '0;
         dac_clear  <= 1'b0;
         clk_sel_8m <= 1'b0;
      end else begin
         bus_ack   <= bus_wr || bus_rd;
         bus_rdata <= bus_rd ? rd_mux : '0;
         dac_clear <= do_clear;
         if (bus_wr && op == OP_CLKSEL) clk_sel_8m <= bus_wdata[0];
      end
   end

   // R2: a broadcast transfer pulses every load line
   a_r2_xfer_loads_all: assert property (@(posedge clk) disable iff (!rst_n)
      do_xfer |=> (dac_load == {NUM_CH{1'b1}}));

   // R5: the clear pulse comes with zero codes and no load
   a_r5_clear_no_load: assert property (@(posedge clk) disable iff (!rst_n)
      dac_clear |-> (dac_load == '0 && dac_code == {CODE_W{1'b0}}));

   // R9: acknowledge follows each strobe by one cycle
   a_r9_ack_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr || bus_rd) |=> bus_ack);

   a_r9_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_wr || bus_rd) |=> !bus_ack);

   // R8: read data is idle outside acknowledge cycles
   a_r8_rdata_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_ack |-> (bus_rdata == '0));

endmodule

// File: tb/dac_dbuf_regbank_tb.sv
module dac_dbuf_regbank_tb_top;

   localparam int N  = 8;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [5:0]    bus_addr = '0;
   logic          bus_wr = 1'b0;
   logic          bus_rd = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          bus_ack;
   logic [N*DW-1:0] dac_code;
   logic [N-1:0]  dac_load;
   logic          dac_clear;
   logic          clk_sel_8m;

   always #10 clk = ~clk;   // 50 MHz

   dac_dbuf_regbank dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .bus_ack(bus_ack), .dac_code(dac_code), .dac_load(dac_load),
      .dac_clear(dac_clear), .clk_sel_8m(clk_sel_8m)
   );

   // Behavioural reference state
   int    m_stage [N];
   int    m_out   [N];
   int    m_load;
   int    m_clear;
   int    m_ack;
   int    m_rdata;
   int    m_sel;
   int    n_checks = 0;
   int    n_fail   = 0;
   string tag = "R10";

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin m_stage[i] = 0; m_out[i] = 0; end
         m_load = 0; m_clear = 0; m_ack = 0; m_rdata = 0; m_sel = 0;
      end else begin
         int a;
         a = int'(bus_addr) & 62;
         m_load = 0; m_clear = 0;
         m_ack = (bus_wr || bus_rd) ? 1 : 0;
         m_rdata = 0;
         if (bus_rd) begin
            if (a < 16)                 m_rdata = m_stage[a/2];
            else if (a >= 32 && a < 48) m_rdata = m_out[(a-32)/2];
            else if (a == 26)           m_rdata = m_sel;
         end
         if (bus_wr) begin
            if (a < 16) m_stage[a/2] = int'(bus_wdata);
            else if (a >= 32 && a < 48) begin
               m_out[(a-32)/2] = int'(bus_wdata);
               m_load = 1 << ((a-32)/2);
            end else if (a == 16) begin
               for (int i = 0; i < N; i++) m_out[i] = m_stage[i];
               m_load = (1 << N) - 1;
            end else if (a == 24) begin
               for (int i = 0; i < N; i++) begin m_stage[i] = 0; m_out[i] = 0; end
               m_clear = 1;
            end else if (a == 26) m_sel = int'(bus_wdata[0]);
         end
      end
   end

   task automatic chk(string req, string what, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   // Compare on every clock, away from the rising edge
   always @(negedge clk) begin
      for (int i = 0; i < N; i++)
         chk(tag, $sformatf("code ch%0d (R2 R3)", i), int'(dac_code[i*DW +: DW]), m_out[i]);
      chk(tag, "load (R4)", int'(dac_load), m_load);
      chk(tag, "clear (R5)", int'(dac_clear), m_clear);
      chk(tag, "ack (R9)", int'(bus_ack), m_ack);
      chk(tag, "rdata (R8)", int'(bus_rdata), m_rdata);
      chk(tag, "clksel (R6)", int'(clk_sel_8m), m_sel);
   end

   task automatic wr(input int addr, input int data, input string t);
      @(negedge clk);
      tag = t;
      bus_addr = 6'(addr); bus_wdata = 16'(data); bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input int addr, input string t);
      @(negedge clk);
      tag = t;
      bus_addr = 6'(addr); bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_checks++; n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R10: reset state
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(2);
      // R1: stage every channel, outputs stay put
      for (int i = 0; i < N; i++) wr(2*i, 16'h1000 + i*16'h111, "R1");
      for (int i = 0; i < N; i++) rd(2*i, "R8");
      // R2: broadcast transfer
      wr(16'h10, 0, "R2");
      idle(2);
      // R3: direct write leaves staging intact, then transfer restores it
      wr(16'h24, 16'hBEEF, "R3");
      rd(16'h24, "R8");
      rd(16'h04, "R3");
      wr(16'h10, 0, "R3");
      // R7: odd offsets alias the even ones
      wr(16'h07, 16'h5A5A, "R7");
      wr(16'h2F, 16'hA5A5, "R7");
      rd(16'h07, "R7");
      // R11: undecoded writes do nothing
      wr(16'h12, 16'hFFFF, "R11");
      wr(16'h1C, 16'hFFFF, "R11");
      wr(16'h3E, 16'hFFFF, "R11");
      rd(16'h12, "R11");
      rd(16'h10, "R8");
      rd(16'h18, "R8");
      // R6: clock select
      wr(16'h1A, 16'hFFFF, "R6");
      rd(16'h1A, "R6");
      wr(16'h1A, 16'hFFFE, "R6");
      rd(16'h1A, "R6");
      // R5: clear all
      wr(16'h18, 0, "R5");
      rd(16'h00, "R5");
      wr(16'h10, 0, "R5");
      // mixed traffic, one access per strobe cycle
      for (int k = 0; k < 2000; k++) begin
         int a;
         a = $urandom_range(0, 63);
         if ($urandom_range(0, 9) == 0) a = 16;
         if ($urandom_range(0, 2) == 0) rd(a, "R8");
         else wr(a, int'($urandom_range(0, 65535)), "R4");
         if ($urandom_range(0, 3) == 0) idle(1);
      end
      // R10: reset in the middle of activity
      wr(16'h22, 16'h1234, "R10");
      @(negedge clk); rst_n = 1'b0; tag = "R10";
      idle(2);
      rst_n = 1'b1;
      idle(2);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule